// File: doc/BRIEF.md
# Debug Register Access Controller

This block is the register front end for a processor's hardware debug registers. It serves reads and writes to eight register indices. Four indices hold breakpoint addresses, one holds a status word and one holds a control word. The remaining two indices act as aliases of the status and control words, but only while the debug-extensions mode input is low. When that mode is high, any access to the two alias indices is refused with an invalid-opcode fault.

Stored status and control words always carry a set of bits that read as one. The block leaves address comparison to a separate breakpoint matcher. It tells that matcher which slots must be re-armed by raising a one-cycle pulse on a per-slot mask.

An access is presented for one cycle on `req_valid`. Writes take effect at that clock edge. Read data, the fault pulse and the re-arm mask are all registered, and they appear in the cycle that follows the request.

Top module: `dbgreg_access_ctrl`

## Requirements
- R1: After synchronous reset, the four address registers read 0, the status word reads 0xFFFF0FF0 and the control word reads 0x00000400. The `fault` and `rearm` outputs are low.
- R2: Indices 0 to 3 write and read address slots 0 to 3 directly. Read data appears on `rd_data` in the cycle after the request and holds until the next read or faulting access.
- R3: A write to index 6 stores the write data ORed with 0xFFFF0FF0.
- R4: A write to index 7 stores the write data ORed with 0x00000400 (bit 10 forced to one).
- R5: With `dbg_ext_en` low, index 4 reads and writes exactly as index 6, and index 5 reads and writes exactly as index 7, including the re-arm behaviour of index 7.
- R6: With `dbg_ext_en` high, any access to index 4 or 5 pulses `fault` for one cycle in the cycle after the request. Such an access changes no register, raises no `rearm` bit and sets `rd_data` to 0.
- R7: A write to address slot i raises `rearm[i]` in the next cycle only when slot i is enabled and its type is not I/O. Slot i is enabled when control bit 2i or bit 2i+1 is set. Its type is control bits [17+4i:16+4i], and 2'b10 means I/O. The control value used is the one held before the write.
- R8: A control write whose stored value differs from the old one only within bits 7:0 raises `rearm[i]` for exactly those slots whose combined enable (bit 2i OR bit 2i+1) changed.
- R9: A control write whose stored value differs from the old one in any bit above bit 7 raises all four `rearm` bits.
- R10: Cycles without a write request, reads, and status writes leave `rearm` at zero. `fault` is never raised except as described in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 3 | Debug register index 0..7 |
| req_wdata | input | 32 | Write data |
| dbg_ext_en | input | 1 | Debug-extensions mode; high disables the 4/5 aliases |
| rd_data | output | 32 | Registered read data |
| fault | output | 1 | One-cycle invalid-opcode fault pulse |
| rearm | output | 4 | One-cycle per-slot re-arm pulse toward the breakpoint matcher |

## Verification
The subtle case is a control write that reaches R8 rather than R9. This happens when the upper bits match the stored word only after bit 10 has been forced, so the new word must equal the old word above bit 7. The stimulus therefore walks all 256 enable-byte values under a fixed upper word, which gives every flip pattern of combined enables, including changes that move only between the local and global bit of a slot. Type fields are then swept across all combinations. After each change, every address slot is written so that R7 is seen against every pairing of enable state and type.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    localparam int DW         = 32;
    localparam int NSLOT      = 4;
    localparam int IDX_W      = 3;
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int EN_BITS    = 2 * NSLOT;
    localparam int TYPE_BASE  = 16;
    localparam int TYPE_STEP  = 4;
    localparam int STAT_IDX   = 6;
    localparam int CTRL_IDX   = 7;
    localparam int STAT_ALIAS = 4;
    localparam int CTRL_ALIAS = 5;

    localparam logic [DW-1:0] STAT_ONES = 32'hFFFF_0FF0;
    localparam logic [DW-1:0] CTRL_ONES = 32'h0000_0400;
    localparam logic [DW-1:0] EN_FIELD  = {{(DW-EN_BITS){1'b0}}, {EN_BITS{1'b1}}};
    localparam logic [1:0]    TYPE_IO   = 2'b10;

    typedef enum logic [1:0] {
        TGT_ADDR  = 2'd0,
        TGT_STAT  = 2'd1,
        TGT_CTRL  = 2'd2,
        TGT_FAULT = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    function automatic logic slot_en(input logic [DW-1:0] c, input int i);
        return c[2*i] | c[2*i+1];
    endfunction

    function automatic logic [1:0] slot_type(input logic [DW-1:0] c, input int i);
        return c[TYPE_BASE + TYPE_STEP*i +: 2];
    endfunction

    function automatic logic [NSLOT-1:0] fold_en(input logic [DW-1:0] c);
        logic [NSLOT-1:0] f;
        for (int i = 0; i < NSLOT; i++) begin
            f[i] = slot_en(c, i);
        end
        return f;
    endfunction

endpackage

// File: rtl/dbgreg_decode.sv
module dbgreg_decode
    import dbgreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             ext,
    output dec_t             dec
);

    always_comb begin
        dec.slot = idx[SLOT_W-1:0];
        if (int'(idx) < NSLOT) begin
            dec.tgt = TGT_ADDR;
        end else if (int'(idx) == STAT_IDX) begin
            dec.tgt = TGT_STAT;
        end else if (int'(idx) == CTRL_IDX) begin
            dec.tgt = TGT_CTRL;
        end else if (int'(idx) == STAT_ALIAS) begin
            dec.tgt = ext ? TGT_FAULT : TGT_STAT;
        end else if (int'(idx) == CTRL_ALIAS) begin
            dec.tgt = ext ? TGT_FAULT : TGT_CTRL;
        end else begin
            dec.tgt = TGT_FAULT;
        end
    end

endmodule

// File: rtl/dbgreg_storage.sv
module dbgreg_storage
    import dbgreg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_addr,
    input  logic                      wr_stat,
    input  logic                      wr_ctrl,
    input  logic [SLOT_W-1:0]         slot,
    input  logic [DW-1:0]             wdata,
    input  logic [DW-1:0]             ctrl_next,
    output logic [NSLOT-1:0][DW-1:0]  addr_q,
    output logic [DW-1:0]             stat_q,
    output logic [DW-1:0]             ctrl_q
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[s] <= '0;
            end else if (wr_addr && slot == SLOT_W'(s)) begin
                addr_q[s] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_ONES;
            ctrl_q <= CTRL_ONES;
        end else begin
            if (wr_stat) begin
                stat_q <= wdata | STAT_ONES;
            end
            if (wr_ctrl) begin
                ctrl_q <= ctrl_next;
            end
        end
    end

endmodule

// File: rtl/dbgreg_rearm_eval.sv
module dbgreg_rearm_eval
    import dbgreg_pkg::*;
(
    input  logic               wr_addr,
    input  logic               wr_ctrl,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [DW-1:0]      ctrl_q,
    input  logic [DW-1:0]      ctrl_next,
    output logic [NSLOT-1:0]   rearm_d
);

    logic upper_diff;

    always_comb begin
        upper_diff = |((ctrl_q ^ ctrl_next) & ~EN_FIELD);
        rearm_d    = '0;
        if (wr_addr) begin
            if (slot_en(ctrl_q, int'(slot)) && slot_type(ctrl_q, int'(slot)) != TYPE_IO) begin
                rearm_d[slot] = 1'b1;
            end
        end else if (wr_ctrl) begin
            if (upper_diff) begin
                rearm_d = '1;
            end else begin
                rearm_d = fold_en(ctrl_q) ^ fold_en(ctrl_next);
            end
        end
    end

endmodule

// File: rtl/dbgreg_access_ctrl.sv
module dbgreg_access_ctrl
    import dbgreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic [DW-1:0]    req_wdata,
    input  logic             dbg_ext_en,
    output logic [DW-1:0]    rd_data,
    output logic             fault,
    output logic [NSLOT-1:0] rearm
);

    dec_t                     dec;
    logic                     acc_ok;
    logic                     acc_bad;
    logic                     wr_addr;
    logic                     wr_stat;
    logic                     wr_ctrl;
    logic [DW-1:0]            ctrl_next;
    logic [NSLOT-1:0][DW-1:0] addr_q;
    logic [DW-1:0]            stat_q;
    logic [DW-1:0]            ctrl_q;
    logic [NSLOT-1:0]         rearm_d;
    logic [DW-1:0]            rd_mux;

    dbgreg_decode u_decode (
        .idx (req_index),
        .ext (dbg_ext_en),
        .dec (dec)
    );

    assign acc_bad   = req_valid && dec.tgt == TGT_FAULT;
    assign acc_ok    = req_valid && dec.tgt != TGT_FAULT;
    assign wr_addr   = acc_ok && req_write && dec.tgt == TGT_ADDR;
    assign wr_stat   = acc_ok && req_write && dec.tgt == TGT_STAT;
    assign wr_ctrl   = acc_ok && req_write && dec.tgt == TGT_CTRL;
    assign ctrl_next = req_wdata | CTRL_ONES;

    dbgreg_storage u_storage (
        .clk       (clk),
        .rst       (rst),
        .wr_addr   (wr_addr),
        .wr_stat   (wr_stat),
        .wr_ctrl   (wr_ctrl),
        .slot      (dec.slot),
        .wdata     (req_wdata),
        .ctrl_next (ctrl_next),
        .addr_q    (addr_q),
        .stat_q    (stat_q),
        .ctrl_q    (ctrl_q)
    );

    dbgreg_rearm_eval u_rearm (
        .wr_addr   (wr_addr),
        .wr_ctrl   (wr_ctrl),
        .slot      (dec.slot),
        .ctrl_q    (ctrl_q),
        .ctrl_next (ctrl_next),
        .rearm_d   (rearm_d)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_ADDR: rd_mux = addr_q[dec.slot];
            TGT_STAT: rd_mux = stat_q;
            TGT_CTRL: rd_mux = ctrl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            fault   <= 1'b0;
            rearm   <= '0;
        end else begin
            fault <= acc_bad;
            rearm <= rearm_d;
            if (acc_bad) begin
                rd_data <= '0;
            end else if (acc_ok && !req_write) begin
                rd_data <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/dbgreg_access_chk.sv
module dbgreg_access_chk
    import dbgreg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [IDX_W-1:0] req_index,
    input logic             dbg_ext_en,
    input logic [DW-1:0]    rd_data,
    input logic             fault,
    input logic [NSLOT-1:0] rearm,
    input logic [DW-1:0]    stat_q,
    input logic [DW-1:0]    ctrl_q
);

    p_fault_cause_r6: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($past(req_valid) && $past(dbg_ext_en) && $past(req_index[2:1]) == 2'b10));

    p_fault_raise_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dbg_ext_en && req_index[2:1] == 2'b10)
        |=> (fault && rearm == '0 && rd_data == '0));

    p_ctrl_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dbg_ext_en && int'(req_index) == CTRL_ALIAS) |=> $stable(ctrl_q));

    p_stat_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_q & STAT_ONES) == STAT_ONES);

    p_ctrl_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & CTRL_ONES) == CTRL_ONES);

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> rearm == '0);

    p_stat_alias_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !dbg_ext_en && int'(req_index) == STAT_ALIAS)
        |=> rd_data == $past(stat_q));

endmodule

bind dbgreg_access_ctrl dbgreg_access_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_index  (req_index),
    .dbg_ext_en (dbg_ext_en),
    .rd_data    (rd_data),
    .fault      (fault),
    .rearm      (rearm),
    .stat_q     (stat_q),
    .ctrl_q     (ctrl_q)
);

// File: tb/test_dbgreg_access_ctrl.sv
`timescale 1ns/1ps
module test_dbgreg_access_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_index = '0;
    logic [31:0] req_wdata = '0;
    logic        dbg_ext_en = 1'b0;
    logic [31:0] rd_data;
    logic        fault;
    logic [3:0]  rearm;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_addr [4];
    logic [31:0] m_stat;
    logic [31:0] m_ctrl;

    always #2.5 clk = ~clk;

    dbgreg_access_ctrl i_dbgreg_access_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_index  (req_index),
        .req_wdata  (req_wdata),
        .dbg_ext_en (dbg_ext_en),
        .rd_data    (rd_data),
        .fault      (fault),
        .rearm      (rearm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] m_fold(input logic [31:0] c);
        logic [3:0] f;
        for (int i = 0; i < 4; i++) f[i] = c[2*i] | c[2*i+1];
        return f;
    endfunction

    // One access; outputs are sampled at the negedge after the capturing edge.
    task automatic access(input logic wr, input int idx, input logic [31:0] d,
                          input logic ext, input string tag);
        logic        bad;
        int          eff;
        logic [3:0]  exp_rearm;
        logic [31:0] exp_rd;
        logic [31:0] n;
        bad = ext && (idx == 4 || idx == 5);
        eff = (idx == 4) ? 6 : (idx == 5) ? 7 : idx;
        exp_rearm = 4'h0;
        exp_rd = 32'h0;
        if (!bad && wr) begin
            if (eff < 4) begin
                if (m_fold(m_ctrl)[eff] && ((m_ctrl >> (16 + 4*eff)) & 32'h3) != 32'h2)
                    exp_rearm = 4'(1 << eff);
            end else if (eff == 7) begin
                n = d | 32'h400;
                if (((m_ctrl ^ n) & 32'hFFFF_FF00) == 0) exp_rearm = m_fold(m_ctrl) ^ m_fold(n);
                else exp_rearm = 4'hF;
            end
        end
        if (!bad && !wr) exp_rd = (eff < 4) ? m_addr[eff] : (eff == 6) ? m_stat : m_ctrl;
        req_valid  = 1'b1;
        req_write  = wr;
        req_index  = 3'(idx);
        req_wdata  = d;
        dbg_ext_en = ext;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bad ? "R6 fault" : "R10 fault", {31'b0, fault}, {31'b0, bad});
        chk(tag, {28'b0, rearm}, {28'b0, exp_rearm});
        if (!wr || bad) chk(bad ? "R6 rd" : tag, rd_data, exp_rd);
        if (!bad && wr) begin
            if (eff < 4) m_addr[eff] = d;
            else if (eff == 6) m_stat = d | 32'hFFFF_0FF0;
            else m_ctrl = d | 32'h400;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_addr[i] = 32'h0;
        m_stat = 32'hFFFF_0FF0;
        m_ctrl = 32'h0000_0400;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 fault", {31'b0, fault}, 32'h0);
        chk("R1 rearm", {28'b0, rearm}, 32'h0);
        for (int i = 0; i < 8; i++) access(1'b0, i, 32'h0, 1'b0, "R1");

        // R2: direct address registers
        for (int i = 0; i < 4; i++) access(1'b1, i, 32'hA5C3_0000 + 32'(i * 32'h1111), 1'b0, "R2");
        for (int i = 0; i < 4; i++) access(1'b0, i, 32'h0, 1'b0, "R2");
        for (int i = 3; i >= 0; i--) begin
            access(1'b1, i, ~(32'h1 << (i * 7)), 1'b0, "R2");
            access(1'b0, i, 32'h0, 1'b0, "R2");
        end

        // R3: status fixed ones; R10: status writes never rearm
        foreach (m_addr[k]) begin
            access(1'b1, 6, 32'(k) * 32'h0F0F_000F, 1'b0, "R3");
            access(1'b0, 6, 32'h0, 1'b0, "R3");
        end
        access(1'b1, 6, 32'hFFFF_FFFF, 1'b0, "R10");
        access(1'b0, 6, 32'h0, 1'b0, "R3");

        // R4: control fixed one, bit 10 cleared in data changes nothing
        access(1'b1, 7, 32'h0000_0000, 1'b0, "R4");
        access(1'b0, 7, 32'h0, 1'b0, "R4");
        access(1'b1, 7, 32'h0033_0003, 1'b0, "R4");
        access(1'b0, 7, 32'h0, 1'b0, "R4");

        // R5: aliases while extensions off
        access(1'b1, 4, 32'h1234_5678, 1'b0, "R5");
        access(1'b0, 6, 32'h0, 1'b0, "R5");
        access(1'b0, 4, 32'h0, 1'b0, "R5");
        access(1'b1, 5, 32'h0000_00FF, 1'b0, "R5");
        access(1'b0, 7, 32'h0, 1'b0, "R5");
        access(1'b1, 5, 32'h0010_00FF, 1'b0, "R5");
        access(1'b0, 5, 32'h0, 1'b0, "R5");

        // R6: aliases fault while extensions on
        for (int w = 0; w < 2; w++) begin
            access(logic'(w), 4, 32'h0000_0000, 1'b1, "R6");
            access(logic'(w), 5, 32'h0000_0000, 1'b1, "R6");
        end
        access(1'b0, 6, 32'h0, 1'b1, "R6");
        access(1'b0, 7, 32'h0, 1'b1, "R6");
        for (int i = 0; i < 8; i++) begin
            if (i != 4 && i != 5) access(1'b0, i, 32'h0, 1'b1, "R6");
        end

        // R8: walk every enable byte under a fixed upper word
        access(1'b1, 7, 32'h0, 1'b0, "R9");
        for (int e = 0; e < 256; e++) access(1'b1, 7, 32'(e), 1'b0, "R8");
        for (int e = 255; e >= 0; e -= 3) access(1'b1, 7, 32'(e), 1'b0, "R8");

        // R7 / R9: all type combinations against several enable patterns
        for (int t = 0; t < 256; t++) begin
            logic [31:0] tf;
            tf = 32'h0;
            for (int s = 0; s < 4; s++) tf |= 32'((t >> (2*s)) & 3) << (16 + 4*s);
            for (int p = 0; p < 4; p++) begin
                logic [7:0] en;
                en = (p == 0) ? 8'h55 : (p == 1) ? 8'hAA : (p == 2) ? 8'(t) : 8'h00;
                access(1'b1, 7, tf | 32'(en), 1'b0, "R9");
                for (int s = 0; s < 4; s++) access(1'b1, s, 32'(t * 16 + s), 1'b0, "R7");
            end
        end
        // R9: length bit change alone rearms all
        access(1'b1, 7, 32'h0000_00FF, 1'b0, "R9");
        access(1'b1, 7, 32'h0004_00FF, 1'b0, "R9");
        access(1'b1, 5, 32'h0000_00FF, 1'b0, "R9");

        // R10: idle cycles are quiet
        repeat (3) begin
            @(negedge clk);
            chk("R10 rearm", {28'b0, rearm}, 32'h0);
            chk("R10 fault", {31'b0, fault}, 32'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule